// File: doc/BRIEF.md
# Bit-Masked PHY Control Register Bank

This block is a small bank of 32-bit control registers with one read-only status word, reached over a plain memory-mapped bus. Each write word has two halves. The upper half holds per-bit write enables for the lower half. A low bit changes only when its enable bit is set, so software can update one field of a register without first reading it. The enable half is never stored.

The bank drives the static controls of an attached storage-interface PHY:

- power-on (the active-low power-down input of the PHY),
- DLL enable,
- output drive strength,
- DLL frequency range,
- output tap delay enable and select.

Two completion flags from the PHY, calibration done and DLL ready, are synchronised into the clock domain. They are then visible in the status word.

Reads are combinational. A read returns the addressed word in the same cycle that `bus_en` is high and `bus_we` is low. A write commits on the rising edge of `clk`.

Top module: `emphy_ctrl_bank`

## Requirements
- R1: After reset, all stored control bits are zero. This means `phy_pwr_on`=0, `phy_dll_en`=0, `phy_drive`=0, `phy_freq_sel`=0, `phy_otap_en`=0, `phy_otap_sel`=0, and every control register reads as 0.
- R2: A write (`bus_en`=1, `bus_we`=1) to a control register works bit by bit on the low half:
  - low bit x takes `bus_wdata[x]` when `bus_wdata[x+16]` is 1;
  - low bit x keeps its old value when `bus_wdata[x+16]` is 0.
  - The new value is visible from the rising edge that commits the write.
- R3: A read of a control register returns the 16 stored bits in bits 15:0 and zero in bits 31:16.
- R4: There are seven independent control registers at byte addresses 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18. A write to one leaves the other six unchanged.
- R5: The register at 0x18 drives three outputs:
  - bit 0 drives `phy_pwr_on`;
  - bit 1 drives `phy_dll_en`;
  - bits 6:4 drive `phy_drive`, coded 0=50 ohm, 1=33 ohm, 2=66 ohm, 3=100 ohm, 4=40 ohm.
- R6: The register at 0x00 drives three outputs:
  - bits 13:12 drive `phy_freq_sel`, coded 0=200 MHz, 1=50 MHz, 2=100 MHz, 3=150 MHz;
  - bit 11 drives `phy_otap_en`;
  - bits 10:7 drive `phy_otap_sel`.
- R7: A read of the status address 0x20 returns two flags, with every other bit zero:
  - bit 6 is `cal_done_i`;
  - bit 5 is `dll_ready_i`.
  - Each flag reflects the input as sampled SYNC_STAGES rising edges earlier (2 by default), and not sooner.
- R8: Writes to the status address, to 0x1C, to addresses above 0x20 and to addresses not a multiple of 4 change no register. Reads of any address other than the seven control registers and the status word return 0.
- R9: With `bus_en`=0, no register changes, whatever `bus_we`, `bus_addr` and `bus_wdata` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write word: [31:16] bit enables, [15:0] values |
| bus_rdata | output | 32 | Read word, combinational |
| cal_done_i | input | 1 | PHY calibration complete flag |
| dll_ready_i | input | 1 | PHY DLL locked flag |
| phy_pwr_on | output | 1 | PHY power-on (active-low power-down input of the PHY) |
| phy_dll_en | output | 1 | PHY DLL enable |
| phy_drive | output | 3 | Drive strength code |
| phy_freq_sel | output | 2 | DLL frequency range code |
| phy_otap_en | output | 1 | Output tap delay enable |
| phy_otap_sel | output | 4 | Output tap delay select |

## Verification
The hardest case to reach from the ports is a write whose value bits disagree with its enable bits. Examples are a low half of all ones with a single enable bit set, or a full low half with no enable set at all. Only these writes separate a true bit-masked merge from a plain store or from a merge keyed on the value bits.

The stimulus builds a known non-trivial register state first. It then issues such mixed words and reads back both the register and the field outputs.

A second hard case is the status latency. Each flag is toggled half a cycle before a read. Reads one edge and two edges later prove that the value appears on the second edge and not the first.

// File: rtl/emphy_regs_pkg.sv
package emphy_regs_pkg;
  localparam int REG_HALF   = 16;
  localparam int REG_DATA_W = 2 * REG_HALF;

  // register holding power and drive controls, and the one holding DLL timing
  localparam int PWR_IDX    = 6;
  localparam int TIMING_IDX = 0;

  // field placement inside the power register
  localparam int PDB_BIT    = 0;
  localparam int DLLEN_BIT  = 1;
  localparam int DRV_LSB    = 4;
  localparam int DRV_W      = 3;

  // field placement inside the timing register
  localparam int OTSEL_LSB  = 7;
  localparam int OTSEL_W    = 4;
  localparam int OTEN_BIT   = 11;
  localparam int FREQ_LSB   = 12;
  localparam int FREQ_W     = 2;

  // status word bits
  localparam int RDY_BIT    = 5;
  localparam int CAL_BIT    = 6;
  localparam int FLAG_W     = 2;

  typedef enum logic [2:0] {
    DRV_50_OHM  = 3'd0,
    DRV_33_OHM  = 3'd1,
    DRV_66_OHM  = 3'd2,
    DRV_100_OHM = 3'd3,
    DRV_40_OHM  = 3'd4
  } drive_code_e;

  typedef enum logic [1:0] {
    FREQ_200M = 2'd0,
    FREQ_50M  = 2'd1,
    FREQ_100M = 2'd2,
    FREQ_150M = 2'd3
  } freq_code_e;

  function automatic logic [REG_HALF-1:0] low_half(input logic [REG_DATA_W-1:0] w);
    return w[REG_HALF-1:0];
  endfunction

  function automatic logic [REG_HALF-1:0] high_half(input logic [REG_DATA_W-1:0] w);
    return w[REG_DATA_W-1:REG_HALF];
  endfunction

  function automatic logic [REG_DATA_W-1:0] status_word(input logic cal, input logic rdy);
    logic [REG_DATA_W-1:0] s;
    s = '0;
    s[CAL_BIT] = cal;
    s[RDY_BIT] = rdy;
    return s;
  endfunction
endpackage

// File: rtl/emphy_addr_decode.sv
module emphy_addr_decode #(
  parameter int ADDR_W        = 8,
  parameter int NUM_CTRL      = 7,
  parameter int STATUS_OFFSET = 32
) (
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  output logic [NUM_CTRL-1:0] wr_hit,
  output logic [NUM_CTRL-1:0] rd_sel,
  output logic                status_sel,
  output logic                any_hit
);
  localparam int STRIDE = 4;

  function automatic logic [NUM_CTRL-1:0] ctrl_match(input logic [ADDR_W-1:0] a);
    logic [NUM_CTRL-1:0] m;
    for (int i = 0; i < NUM_CTRL; i++) begin
      m[i] = (a == ADDR_W'(STRIDE * i));
    end
    return m;
  endfunction

  function automatic logic status_match(input logic [ADDR_W-1:0] a);
    return a == ADDR_W'(STATUS_OFFSET);
  endfunction

  logic [NUM_CTRL-1:0] ctrl_m;
  logic                stat_m;
  logic                rd_cyc;
  logic                wr_cyc;

  assign ctrl_m     = ctrl_match(bus_addr);
  assign stat_m     = status_match(bus_addr);
  assign wr_cyc     = bus_en & bus_we;
  assign rd_cyc     = bus_en & ~bus_we;
  assign wr_hit     = wr_cyc ? ctrl_m : '0;
  assign rd_sel     = rd_cyc ? ctrl_m : '0;
  assign status_sel = rd_cyc & stat_m;
  assign any_hit    = (|ctrl_m) | stat_m;
endmodule

// File: rtl/emphy_masked_reg.sv
module emphy_masked_reg #(
  parameter int               WIDTH     = 16,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_val,
  input  logic [WIDTH-1:0] wr_mask,
  output logic [WIDTH-1:0] q
);
  function automatic logic [WIDTH-1:0] merge_bits(
    input logic [WIDTH-1:0] old_v,
    input logic [WIDTH-1:0] new_v,
    input logic [WIDTH-1:0] en_v
  );
    return (old_v & ~en_v) | (new_v & en_v);
  endfunction

  logic [WIDTH-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= RESET_VAL;
    end else if (wr_en) begin
      q_r <= merge_bits(q_r, wr_val, wr_mask);
    end
  end

  assign q = q_r;

  // enabled bits take the written value
  assert_masked_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & $past(wr_mask)) == ($past(wr_val) & $past(wr_mask))));

  // bits without an enable keep their value
  assert_masked_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & ~$past(wr_mask)) == ($past(q) & ~$past(wr_mask))));

  // no write strobe, no change
  assert_no_strobe_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/emphy_status_sync.sv
module emphy_status_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES == 0) begin : g_direct
      assign q = d;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_r [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stage_r[i] <= '0;
        end else begin
          stage_r[0] <= d;
          for (int i = 1; i < STAGES; i++) stage_r[i] <= stage_r[i-1];
        end
      end
      assign q = stage_r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/emphy_ctrl_bank.sv
module emphy_ctrl_bank
  import emphy_regs_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int NUM_CTRL      = 7,
  parameter int STATUS_OFFSET = 32,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [REG_DATA_W-1:0] bus_wdata,
  output logic [REG_DATA_W-1:0] bus_rdata,
  input  logic                  cal_done_i,
  input  logic                  dll_ready_i,
  output logic                  phy_pwr_on,
  output logic                  phy_dll_en,
  output logic [DRV_W-1:0]      phy_drive,
  output logic [FREQ_W-1:0]     phy_freq_sel,
  output logic                  phy_otap_en,
  output logic [OTSEL_W-1:0]    phy_otap_sel
);
  logic [NUM_CTRL-1:0] wr_hit;
  logic [NUM_CTRL-1:0] rd_sel;
  logic                status_sel;
  logic                any_hit;
  logic [REG_HALF-1:0] ctrl_q [NUM_CTRL];
  logic [REG_HALF-1:0] wr_val;
  logic [REG_HALF-1:0] wr_mask;
  logic [FLAG_W-1:0]   flags_sync;
  logic [REG_DATA_W-1:0] rdata_c;

  assign wr_val  = low_half(bus_wdata);
  assign wr_mask = high_half(bus_wdata);

  emphy_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL), .STATUS_OFFSET(STATUS_OFFSET)
  ) u_decode (
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .wr_hit(wr_hit), .rd_sel(rd_sel), .status_sel(status_sel), .any_hit(any_hit)
  );

  generate
    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
      emphy_masked_reg #(.WIDTH(REG_HALF), .RESET_VAL('0)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_hit[i]),
        .wr_val(wr_val), .wr_mask(wr_mask), .q(ctrl_q[i])
      );
    end
  endgenerate

  emphy_status_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cal_done_i, dll_ready_i}), .q(flags_sync)
  );

  always_comb begin
    rdata_c = '0;
    for (int i = 0; i < NUM_CTRL; i++) begin
      if (rd_sel[i]) rdata_c = {{REG_HALF{1'b0}}, ctrl_q[i]};
    end
    if (status_sel) rdata_c = status_word(flags_sync[1], flags_sync[0]);
  end

  assign bus_rdata = rdata_c;

  assign phy_pwr_on   = ctrl_q[PWR_IDX][PDB_BIT];
  assign phy_dll_en   = ctrl_q[PWR_IDX][DLLEN_BIT];
  assign phy_drive    = ctrl_q[PWR_IDX][DRV_LSB +: DRV_W];
  assign phy_freq_sel = ctrl_q[TIMING_IDX][FREQ_LSB +: FREQ_W];
  assign phy_otap_en  = ctrl_q[TIMING_IDX][OTEN_BIT];
  assign phy_otap_sel = ctrl_q[TIMING_IDX][OTSEL_LSB +: OTSEL_W];

  assert_single_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_sel) |-> (bus_rdata[REG_DATA_W-1:REG_HALF] == '0));

  assert_undecoded_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !any_hit) |-> (bus_rdata == '0));

  assert_status_bits_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status_sel |-> ((bus_rdata & ~status_word(1'b1, 1'b1)) == '0));

  assert_idle_outputs_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> ($stable(phy_pwr_on) && $stable(phy_dll_en) && $stable(phy_drive) &&
                 $stable(phy_freq_sel) && $stable(phy_otap_en) && $stable(phy_otap_sel)));
endmodule

// File: tb/tb_emphy_ctrl_bank.sv
module tb_emphy_ctrl_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cal_done_i = 1'b0;
  logic        dll_ready_i = 1'b0;
  logic        phy_pwr_on, phy_dll_en, phy_otap_en;
  logic [2:0]  phy_drive;
  logic [1:0]  phy_freq_sel;
  logic [3:0]  phy_otap_sel;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [15:0] model [7];

  always #5 clk = ~clk;

  emphy_ctrl_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cal_done_i(cal_done_i), .dll_ready_i(dll_ready_i),
    .phy_pwr_on(phy_pwr_on), .phy_dll_en(phy_dll_en), .phy_drive(phy_drive),
    .phy_freq_sel(phy_freq_sel), .phy_otap_en(phy_otap_en), .phy_otap_sel(phy_otap_sel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // bench-side restatement of the masked rule: walk the enable bits one by one
  function automatic logic [15:0] apply_write(input logic [15:0] old_v, input logic [31:0] w);
    logic [15:0] r;
    r = old_v;
    for (int b = 0; b < 16; b++) if (w[16 + b]) r[b] = w[b];
    return r;
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] w);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = w;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    if (a[1:0] == 2'b00 && a <= 8'h18) model[a >> 2] = apply_write(model[a >> 2], w);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] r);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 r = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic check_outputs(input string req);
    check({req, " pwr_on"},   {31'b0, phy_pwr_on},   {31'b0, model[6][0]});
    check({req, " dll_en"},   {31'b0, phy_dll_en},   {31'b0, model[6][1]});
    check({req, " drive"},    {29'b0, phy_drive},    {29'b0, model[6][6:4]});
    check({req, " freq"},     {30'b0, phy_freq_sel}, {30'b0, model[0][13:12]});
    check({req, " otap_en"},  {31'b0, phy_otap_en},  {31'b0, model[0][11]});
    check({req, " otap_sel"}, {28'b0, phy_otap_sel}, {28'b0, model[0][10:7]});
  endtask

  task automatic check_all_regs(input string req);
    logic [31:0] r;
    for (int i = 0; i < 7; i++) begin
      bus_read(8'(4 * i), r);
      check(req, r, {16'h0, model[i]});
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < 7; i++) model[i] = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_outputs("R1 reset");
    check_all_regs("R1 reset readback");
  endtask

  task automatic t_masked;
    logic [31:0] r;
    bus_write(8'h18, 32'h0001_0001);
    check("R5 power-on bit", {31'b0, phy_pwr_on}, 32'd1);
    bus_write(8'h18, 32'h0002_FFFF);            // only bit 1 enabled
    bus_read(8'h18, r);
    check("R2 single enable", r, 32'h0000_0003);
    bus_write(8'h18, 32'h0000_FFFF);            // no enables at all
    bus_read(8'h18, r);
    check("R2 zero enables", r, 32'h0000_0003);
    bus_write(8'h18, 32'h0070_0040);            // drive = 40 ohm
    check("R5 drive 40 ohm", {29'b0, phy_drive}, 32'd4);
    bus_write(8'h18, 32'h0003_0000);            // power down, DLL off, drive kept
    bus_read(8'h18, r);
    check("R2 clear two bits", r, 32'h0000_0040);
    check_outputs("R5 after power down");
  endtask

  task automatic t_timing;
    bus_write(8'h00, 32'h3F80_2A00);            // freq 100 MHz, tap en, tap 4
    check("R6 freq 100M", {30'b0, phy_freq_sel}, 32'd2);
    check("R6 tap enable", {31'b0, phy_otap_en}, 32'd1);
    check("R6 tap select", {28'b0, phy_otap_sel}, 32'd4);
    bus_write(8'h00, 32'h3000_1000);            // freq 50 MHz, tap fields kept
    check_outputs("R6 freq 50M");
  endtask

  task automatic t_upper_zero;
    logic [31:0] r;
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h04, r);
    check("R3 upper half zero", r, 32'h0000_FFFF);
  endtask

  task automatic t_independent;
    for (int i = 1; i < 6; i++) bus_write(8'(4 * i), {16'hFFFF, 16'(16'h1111 * i)});
    bus_write(8'h0C, 32'h00F0_0000);
    check_all_regs("R4 independent registers");
    check_outputs("R4 outputs untouched");
  endtask

  task automatic t_status;
    logic [31:0] r;
    @(negedge clk) cal_done_i = 1'b1;
    bus_read(8'h20, r);
    check("R7 cal one edge", r, 32'h0000_0000);
    bus_read(8'h20, r);
    check("R7 cal two edges", r, 32'h0000_0040);
    @(negedge clk) dll_ready_i = 1'b1;
    bus_read(8'h20, r);
    check("R7 rdy one edge", r, 32'h0000_0040);
    bus_read(8'h20, r);
    check("R7 rdy two edges", r, 32'h0000_0060);
  endtask

  task automatic t_ignored;
    logic [31:0] r;
    bus_write(8'h20, 32'hFFFF_FFFF);
    bus_write(8'h1C, 32'hFFFF_FFFF);
    bus_write(8'h24, 32'hFFFF_FFFF);
    bus_write(8'h1A, 32'hFFFF_FFFF);
    bus_write(8'h02, 32'hFFFF_FFFF);
    bus_write(8'hFC, 32'hFFFF_FFFF);
    check_all_regs("R8 ignored writes");
    check_outputs("R8 ignored outputs");
    bus_read(8'h1C, r); check("R8 read 0x1C", r, 32'h0);
    bus_read(8'h24, r); check("R8 read 0x24", r, 32'h0);
    bus_read(8'h02, r); check("R8 read 0x02", r, 32'h0);
    bus_read(8'h20, r); check("R8 status unchanged", r, 32'h0000_0060);
  endtask

  task automatic t_no_strobe;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b1; bus_addr = 8'h18; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_addr = 8'h00;
    @(negedge clk);
    bus_we = 1'b0;
    check_outputs("R9 strobe low");
    check_all_regs("R9 strobe low readback");
  endtask

  initial begin
    t_reset();
    t_masked();
    t_timing();
    t_upper_zero();
    t_independent();
    t_status();
    t_ignored();
    t_no_strobe();
    t_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule